// File: doc/BRIEF.md
# Automatic Recording Level Controller

This block closes a gain loop around a programmable-gain amplifier that sits in front of an ADC. It takes the converter's signed stereo samples and finds the magnitude of the one channel it has been told to watch. It then moves a 6-bit gain code up or down by one code at a time, so that the recorded peak settles near a programmable target level. A code of 23 (decimal) means 0 dB. Each code step is 1.5 dB.

The attack rate (how fast gain comes down) and the decay rate (how fast gain goes back up) are separate. Each is set by a 4-bit code that doubles the interval per code. A 3-bit setting caps the gain in 6 dB steps. A noise gate watches for very quiet input. Below its threshold it either freezes the gain or freezes the gain and raises a mute flag.

When neither channel is selected, the loop is idle and the gain output simply follows a register-programmed volume code. This lets software take back manual control at any time.

Top module: `pga_level_loop`

## Requirements
- R1: With channel select 00 or 11 the loop is off. One clock after any cycle, `gain_code` equals the `vol_code` of that cycle, and `mute` is low. Samples have no effect.
- R2: Channel select 01 watches only `smp_right` and 10 watches only `smp_left`. The unwatched channel has no effect on the gain.
- R3: The target magnitude for target code t is 2^23·10^((−28.5+1.5t)/20), so code 15 is −6 dBFS. A watched magnitude strictly above the target counts toward attack. A magnitude at or below the target counts toward decay. Negative samples use their absolute value.
- R4: After ATK_UNIT·2^a consecutive attack strobes (a = attack code, codes above 10 act as 10), the gain code falls by one. The counter then restarts. The gain never goes below 0.
- R5: After DCY_UNIT·2^d consecutive decay strobes (d = decay code, clamped at 10), the gain code rises by one. It never exceeds the ceiling 15+4·m, where m is the 3-bit ceiling code (m = 0 is −12 dB, m = 7 is +30 dB). If the gain is above the ceiling, any enabled strobe sets it to the ceiling.
- R6: A strobe whose direction (attack or decay) differs from the previous counted strobe restarts the count at one.
- R7: With the gate enabled and the watched magnitude strictly below the gate level, the strobe freezes the gain and clears the step count. The gate level for gate code g is 2^23·10^((−76.5+1.5g)/20). Gate modes 00, 10 and 11 leave `mute` low.
- R8: In gate mode 01 a gated strobe sets `mute` high. The next non-gated enabled strobe clears it. With the gate disabled, quiet input is treated as decay.
- R9: After reset `gain_code` is 23 and `mute` is low.
- R10: While enabled, the gain, mute and step count change only on a sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| chan_sel | input | 2 | 00/11 off, 01 right, 10 left |
| target_code | input | 4 | Target level code |
| ceil_code | input | 3 | Gain ceiling code |
| atk_code | input | 4 | Attack interval code |
| dcy_code | input | 4 | Decay interval code |
| gate_en | input | 1 | Noise gate enable |
| gate_mode | input | 2 | 01 mute, others hold |
| gate_code | input | 5 | Gate threshold code |
| vol_code | input | 6 | Manual gain code used when off |
| gain_code | output | 6 | PGA gain code |
| mute | output | 1 | Gate mute flag |

## Verification
Every result is one register stage away from its cause. A strobe or a change of `chan_sel` or `vol_code` shows on `gain_code` and `mute` right after the next rising edge. The bench changes inputs on falling edges and reads outputs at the following falling edge, a half cycle after that rising edge. Step timing is checked by sending exactly one strobe fewer than the interval and confirming the code has not moved, then one more strobe and confirming a single step. Threshold sweeps place samples 5 to 10 percent either side of each level, so the 1.5 dB grid is checked without relying on rounding of the last bit.

// File: rtl/pga_level_loop.sv
module pga_level_loop #(
  parameter int SW         = 24,
  parameter int GW         = 6,
  parameter int ATK_UNIT   = 5,
  parameter int DCY_UNIT   = 20,
  parameter int MAX_CODE   = 10,
  parameter int GAIN_RESET = 23,
  parameter int CEIL_BASE  = 15,
  parameter int CEIL_STEP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  input  logic [1:0]    chan_sel,
  input  logic [3:0]    target_code,
  input  logic [2:0]    ceil_code,
  input  logic [3:0]    atk_code,
  input  logic [3:0]    dcy_code,
  input  logic          gate_en,
  input  logic [1:0]    gate_mode,
  input  logic [4:0]    gate_code,
  input  logic [GW-1:0] vol_code,
  output logic [GW-1:0] gain_code,
  output logic          mute
);
  localparam int MAXU = (ATK_UNIT > DCY_UNIT) ? ATK_UNIT : DCY_UNIT;
  localparam int CW   = $clog2(MAXU * (1 << MAX_CODE) + 1);

  function automatic logic [SW-1:0] level_of(input logic [5:0] n);
    logic [63:0] k;
    case (n[1:0])
      2'd0:    k = 64'd8388608;
      2'd1:    k = 64'd7058075;
      2'd2:    k = 64'd5938681;
      default: k = 64'd4996775;
    endcase
    return SW'(((k << (SW - 1)) >> 23) >> n[5:2]);
  endfunction

  logic          en, over, gated, dir, step;
  logic [SW-1:0] smp, mag, tgt_lvl, gate_lvl;
  logic [5:0]    tgt_n, gate_n;
  logic [3:0]    atk_eff, dcy_eff;
  logic [CW-1:0] cnt, cnt_nx, len;
  logic [GW-1:0] ceil_lim;

  assign en       = chan_sel[0] ^ chan_sel[1];
  assign smp      = chan_sel[0] ? smp_right : smp_left;
  assign mag      = smp[SW-1] ? (~smp + 1'b1) : smp;
  assign tgt_n    = 6'd19 - {2'b00, target_code};
  assign gate_n   = 6'd51 - {1'b0, gate_code};
  assign tgt_lvl  = level_of(tgt_n);
  assign gate_lvl = level_of(gate_n);
  assign over     = mag > tgt_lvl;
  assign gated    = gate_en && (mag < gate_lvl);
  assign atk_eff  = (atk_code > 4'(MAX_CODE)) ? 4'(MAX_CODE) : atk_code;
  assign dcy_eff  = (dcy_code > 4'(MAX_CODE)) ? 4'(MAX_CODE) : dcy_code;
  assign len      = over ? (CW'(ATK_UNIT) << atk_eff) : (CW'(DCY_UNIT) << dcy_eff);
  assign cnt_nx   = (over != dir) ? CW'(1) : cnt + CW'(1);
  assign step     = cnt_nx >= len;
  assign ceil_lim = GW'(CEIL_BASE + CEIL_STEP * int'(ceil_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_code <= GW'(GAIN_RESET);
      mute      <= 1'b0;
      cnt       <= '0;
      dir       <= 1'b0;
    end else if (!en) begin
      gain_code <= vol_code;
      mute      <= 1'b0;
      cnt       <= '0;
    end else if (smp_valid) begin
      mute <= gated && (gate_mode == 2'b01);
      if (gain_code > ceil_lim) begin
        gain_code <= ceil_lim;
        cnt       <= '0;
      end else if (gated) begin
        cnt <= '0;
      end else begin
        dir <= over;
        if (step) begin
          cnt <= '0;
          if (over && gain_code != '0)
            gain_code <= gain_code - 1'b1;
          else if (!over && gain_code < ceil_lim)
            gain_code <= gain_code + 1'b1;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end
endmodule

// File: rtl/pga_level_loop_chk.sv
module pga_level_loop_chk #(
  parameter int GW        = 6,
  parameter int CEIL_BASE = 15,
  parameter int CEIL_STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [1:0]    chan_sel,
  input logic [2:0]    ceil_code,
  input logic          gate_en,
  input logic [1:0]    gate_mode,
  input logic [GW-1:0] vol_code,
  input logic [GW-1:0] gain_code,
  input logic          mute
);
  logic          on;
  logic [GW-1:0] cap;
  assign on  = (chan_sel == 2'b01) || (chan_sel == 2'b10);
  assign cap = GW'(CEIL_BASE + CEIL_STEP * int'(ceil_code));

  // R1
  off_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (gain_code == $past(vol_code)) && !mute);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !smp_valid) |=> $stable(gain_code) && $stable(mute));

  // R5
  gain_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && smp_valid) |=> gain_code <= $past(cap));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && smp_valid && gain_code <= cap) |=>
      (int'(gain_code) <= int'($past(gain_code)) + 1) &&
      (int'(gain_code) + 1 >= int'($past(gain_code))));

  // R8
  mute_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> $past(on && smp_valid && gate_en && gate_mode == 2'b01));
endmodule

bind pga_level_loop pga_level_loop_chk #(.GW(GW), .CEIL_BASE(CEIL_BASE), .CEIL_STEP(CEIL_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .chan_sel(chan_sel),
  .ceil_code(ceil_code), .gate_en(gate_en), .gate_mode(gate_mode),
  .vol_code(vol_code), .gain_code(gain_code), .mute(mute)
);

// File: tb/pga_level_loop_bench.sv
`timescale 1ns/1ps
module pga_level_loop_bench;
  localparam int AU = 2;
  localparam int DU = 3;

  logic        clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic [1:0]  chan_sel = 2'b00;
  logic [3:0]  target_code = 4'd15, atk_code = 4'd0, dcy_code = 4'd0;
  logic [2:0]  ceil_code = 3'd7;
  logic        gate_en = 1'b0;
  logic [1:0]  gate_mode = 2'b00;
  logic [4:0]  gate_code = 5'd0;
  logic [5:0]  vol_code = 6'd0;
  logic [5:0]  gain_code;
  logic        mute;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pga_level_loop #(.ATK_UNIT(AU), .DCY_UNIT(DU)) u_pga_level_loop (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .chan_sel(chan_sel), .target_code(target_code),
    .ceil_code(ceil_code), .atk_code(atk_code), .dcy_code(dcy_code),
    .gate_en(gate_en), .gate_mode(gate_mode), .gate_code(gate_code),
    .vol_code(vol_code), .gain_code(gain_code), .mute(mute)
  );

  function automatic int amp(real db, real k);
    return int'(k * 8388608.0 * $pow(10.0, db / 20.0));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(int l, int r, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_left = 24'(l); smp_right = 24'(r);
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic load(int v, logic [1:0] sel);
    @(negedge clk); chan_sel = 2'b00; vol_code = 6'(v);
    @(negedge clk); chan_sel = sel;
    @(negedge clk);
  endtask

  localparam int LOUD  = 7549747;
  localparam int QUIET = 838861;

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk("R9 gain", int'(gain_code), 23);
    chk("R9 mute", int'(mute), 0);
    rst_n = 1'b1;

    // R1 sweep of manual code, off codes 00 and 11
    for (int v = 0; v < 64; v++) begin
      @(negedge clk); vol_code = 6'(v); chan_sel = (v % 2) ? 2'b11 : 2'b00;
      smp_valid = 1'b1; smp_left = 24'(LOUD); smp_right = 24'(LOUD);
      @(negedge clk);
      chk("R1 follow", int'(gain_code), v);
      chk("R1 mute", int'(mute), 0);
    end
    smp_valid = 1'b0;

    // R4 attack interval per code
    for (int a = 0; a < 4; a++) begin
      atk_code = 4'(a);
      load(30, 2'b10);
      strobe(LOUD, 0, (AU << a) - 1);
      chk("R4 before step", int'(gain_code), 30);
      strobe(-LOUD, 0, 1);
      chk("R4 step", int'(gain_code), 29);
    end
    atk_code = 4'd15;
    load(30, 2'b10);
    strobe(LOUD, 0, (AU << 10) - 1);
    chk("R4 clamped code before", int'(gain_code), 30);
    strobe(LOUD, 0, 1);
    chk("R4 clamped code step", int'(gain_code), 29);
    atk_code = 4'd0;
    load(1, 2'b10);
    strobe(LOUD, 0, AU);
    chk("R4 reach zero", int'(gain_code), 0);
    strobe(LOUD, 0, AU);
    chk("R4 floor", int'(gain_code), 0);

    // R5 decay interval per code
    for (int d = 0; d < 4; d++) begin
      dcy_code = 4'(d);
      load(20, 2'b10);
      strobe(QUIET, 0, (DU << d) - 1);
      chk("R5 before step", int'(gain_code), 20);
      strobe(QUIET, 0, 1);
      chk("R5 step", int'(gain_code), 21);
    end
    dcy_code = 4'd0;
    for (int m = 0; m < 8; m++) begin
      ceil_code = 3'(m);
      load(63, 2'b10);
      strobe(QUIET, 0, 1);
      chk("R5 clamp to ceiling", int'(gain_code), 15 + 4 * m);
      strobe(QUIET, 0, 2 * DU);
      chk("R5 stays at ceiling", int'(gain_code), 15 + 4 * m);
    end
    ceil_code = 3'd7;

    // R6 direction change restarts count
    atk_code = 4'd2;
    load(30, 2'b10);
    strobe(LOUD, 0, 5);
    strobe(QUIET, 0, 1);
    strobe(LOUD, 0, (AU << 2) - 1);
    chk("R6 restarted count", int'(gain_code), 30);
    strobe(LOUD, 0, 1);
    chk("R6 step after full count", int'(gain_code), 29);
    atk_code = 4'd0;

    // R3 target sweep
    load(30, 2'b10);
    for (int t = 0; t < 16; t++) begin
      real db;
      target_code = 4'(t);
      db = -28.5 + 1.5 * t;
      strobe(amp(db, 1.05), 0, AU - 1);
      strobe(-amp(db, 1.05), 0, 1);
      chk("R3 above target", int'(gain_code), 29);
      strobe(amp(db, 0.95), 0, DU);
      chk("R3 below target", int'(gain_code), 30);
    end
    target_code = 4'd15;

    // R2 channel selection
    load(30, 2'b01);
    strobe(LOUD, QUIET, DU);
    chk("R2 right watched, left ignored", int'(gain_code), 31);
    strobe(QUIET, LOUD, AU);
    chk("R2 right loud", int'(gain_code), 30);
    load(30, 2'b10);
    strobe(QUIET, LOUD, DU);
    chk("R2 left watched, right ignored", int'(gain_code), 31);

    // R10 no change between strobes
    load(30, 2'b10);
    strobe(LOUD, 0, 1);
    repeat (20) @(negedge clk);
    chk("R10 idle hold", int'(gain_code), 30);
    strobe(LOUD, 0, 1);
    chk("R10 count kept", int'(gain_code), 29);

    // R7 gate hold sweep
    gate_en = 1'b1;
    load(5, 2'b10);
    for (int g = 0; g < 32; g++) begin
      real db;
      gate_code = 5'(g);
      gate_mode = (g % 3 == 0) ? 2'b00 : ((g % 3 == 1) ? 2'b10 : 2'b11);
      db = -76.5 + 1.5 * g;
      strobe(amp(db, 0.9), 0, 2 * DU);
      chk("R7 gated hold", int'(gain_code), 5 + g);
      chk("R7 no mute", int'(mute), 0);
      strobe(amp(db, 1.1), 0, DU);
      chk("R7 above gate", int'(gain_code), 6 + g);
    end

    // R8 gate mute
    gate_mode = 2'b01; gate_code = 5'd10;
    load(30, 2'b10);
    strobe(amp(-61.5, 0.9), 0, 1);
    chk("R8 mute set", int'(mute), 1);
    chk("R8 gain held", int'(gain_code), 30);
    repeat (5) @(negedge clk);
    chk("R8 mute kept", int'(mute), 1);
    strobe(amp(-61.5, 1.1), 0, 1);
    chk("R8 mute cleared", int'(mute), 0);
    gate_en = 1'b0;
    load(30, 2'b10);
    strobe(amp(-61.5, 0.9), 0, DU);
    chk("R8 gate off decays", int'(gain_code), 31);
    chk("R8 gate off no mute", int'(mute), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule